// File: doc/BRIEF.md
# Servo DC Offset Averaging and Trim

This block removes slow DC offsets from four sampled servo channels: the system centre voltage, the focus error, the tracking error and the RF level. Software writes a command word together with an 8-bit address. When the address is the trim-control address 0x38, the word can start offset measurements and select how the live samples are corrected. A measurement sums 256 consecutive strobed samples of every requested channel in parallel. It then keeps the mean, rounded toward minus infinity, as that channel's stored offset.

The correction datapath is combinational from the live samples and the stored offsets. The focus path can subtract either the centre offset or its own offset. The tracking path has the same two choices. The RF path subtracts its own offset and never goes below zero. A separate focus zero-cross output always carries focus minus the focus offset. Every corrected value saturates to the signed 8-bit range. A busy status shows while a measurement runs, but only while the last latched address is 0x38, so software polls it by latching a word at that address.

Top module: `dc_offset_trim`

## Requirements
- R1: After reset all stored offsets are 0, the status output is low and no correction is selected, so fcs_out, trk_out and rf_out equal their raw inputs and fzc_out equals fe_in.
- R2: Latching a word at address 0x38 starts a measurement for each channel whose start bit is 1: bit 15 centre, bit 13 focus, bit 11 RF, bit 4 tracking. After the 256th counted strobe, each requested offset becomes floor(sum of its 256 samples / 256).
- R3: A channel whose start bit was 0 keeps its stored offset through a measurement of other channels.
- R4: A strobe is counted only in a cycle after the latch cycle and while a measurement is running. Busy is high from the cycle after the latch until the cycle after the 256th counted strobe. Strobes that arrive while idle have no effect.
- R5: status_out equals busy only while the last latched address is 0x38 and is low otherwise. Latching a different address hides busy without stopping the running measurement.
- R6: A new latch at 0x38 during a measurement discards the partial sums and restarts with the new start bits. With no start bits set, the measurement ends at once and the stored offsets are unchanged.
- R7: With bit 12 set, rf_out = rf_in - RF offset, forced to 0 when that difference is negative. With bit 12 clear, rf_out = rf_in.
- R8: fcs_out = fe_in - focus offset when bit 10 is set. It is fe_in - centre offset when bit 10 is clear and bit 3 is set, and fe_in otherwise.
- R9: trk_out = te_in - tracking offset when bit 1 is set. It is te_in - centre offset when bit 1 is clear and bit 2 is set, and te_in otherwise.
- R10: fzc_out is always fe_in - focus offset, whatever the selection bits.
- R11: Each corrected difference saturates to [-128, 127] instead of wrapping.
- R12: A latch at any address other than 0x38 changes neither the correction selection nor the measurement state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | One-cycle latch strobe for address and data |
| cmd_addr | input | 8 | Command address |
| cmd_data | input | 16 | Command data word |
| smp_stb | input | 1 | One-cycle sample strobe |
| vc_in | input | 8 | Centre voltage sample, signed |
| fe_in | input | 8 | Focus error sample, signed |
| rf_in | input | 8 | RF level sample, signed |
| te_in | input | 8 | Tracking error sample, signed |
| fcs_out | output | 8 | Corrected focus value, signed |
| trk_out | output | 8 | Corrected tracking value, signed |
| rf_out | output | 8 | Corrected RF value, signed |
| fzc_out | output | 8 | Focus zero-cross input, signed |
| status_out | output | 1 | Measurement busy, shown only at address 0x38 |

## Verification
Measurements are run with random samples, which exercise the floor division of mixed-sign sums. They are also run with constant extreme samples of -128 and 127, which pin the offset at the range limits and then drive the saturation and zero-floor corners. Random selection words with random live samples separate the priority of the own-offset bit from the centre-offset bit on each path. A foreign-address latch in mid-measurement, a restart, an abort and a strobe that coincides with the latch each distinguish a counter that follows the rules from one that counts or keeps samples it should drop.

// File: rtl/dco_pkg.sv
package dco_pkg;
    localparam int SMP_W  = 8;
    localparam int LOG_N  = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int NCH    = 4;

    localparam logic [ADDR_W-1:0] TRIM_ADDR = 8'h38;

    // channel slots in the accumulator array
    localparam int CH_VC = 0;
    localparam int CH_FE = 1;
    localparam int CH_RF = 2;
    localparam int CH_TE = 3;

    // command word bit positions
    localparam int B_MEAS_VC = 15;
    localparam int B_MEAS_FE = 13;
    localparam int B_MEAS_RF = 11;
    localparam int B_MEAS_TE = 4;
    localparam int B_RF_FLR  = 12;
    localparam int B_FE_OWN  = 10;
    localparam int B_FE_VC   = 3;
    localparam int B_TE_VC   = 2;
    localparam int B_TE_OWN  = 1;

    typedef struct packed {
        logic rf_floor;
        logic fe_own;
        logic fe_vc;
        logic te_own;
        logic te_vc;
    } trim_sel_t;
endpackage

// File: rtl/dco_ctrl.sv
module dco_ctrl
    import dco_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int DATA_W_P = DATA_W,
    parameter int LOG_N_P  = LOG_N,
    parameter int NCH_P    = NCH,
    parameter logic [ADDR_W_P-1:0] SEL_ADDR = TRIM_ADDR
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_load,
    input  logic [ADDR_W_P-1:0] cmd_addr,
    input  logic [DATA_W_P-1:0] cmd_data,
    input  logic                smp_stb,
    output logic                restart,
    output logic                take,
    output logic                last,
    output logic [NCH_P-1:0]    mask,
    output trim_sel_t           sel,
    output logic                status
);
    localparam logic [LOG_N_P-1:0] CNT_END = '1;
    localparam logic [LOG_N_P-1:0] CNT_ONE = LOG_N_P'(1);

    typedef struct packed {
        logic [ADDR_W_P-1:0] addr;
        logic [NCH_P-1:0]    mask;
        logic [LOG_N_P-1:0]  cnt;
        trim_sel_t           sel;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     hit;
    logic     busy;
    logic [NCH_P-1:0] req;

    always_comb begin
        hit  = cmd_load && (cmd_addr == SEL_ADDR);
        req  = '0;
        req[CH_VC] = cmd_data[B_MEAS_VC];
        req[CH_FE] = cmd_data[B_MEAS_FE];
        req[CH_RF] = cmd_data[B_MEAS_RF];
        req[CH_TE] = cmd_data[B_MEAS_TE];
        busy = |st_q.mask;
        take = smp_stb && busy && !hit;
        last = take && (st_q.cnt == CNT_END);
        restart = hit;

        st_d = st_q;
        if (cmd_load) begin
            st_d.addr = cmd_addr;
        end
        if (hit) begin
            st_d.mask         = req;
            st_d.cnt          = '0;
            st_d.sel.rf_floor = cmd_data[B_RF_FLR];
            st_d.sel.fe_own   = cmd_data[B_FE_OWN];
            st_d.sel.fe_vc    = cmd_data[B_FE_VC];
            st_d.sel.te_own   = cmd_data[B_TE_OWN];
            st_d.sel.te_vc    = cmd_data[B_TE_VC];
        end else if (take) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
            if (last) begin
                st_d.mask = '0;
            end
        end

        mask   = st_q.mask;
        sel    = st_q.sel;
        status = busy && (st_q.addr == SEL_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    wire unused_cmd = ^cmd_data;

    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_load));
    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !cmd_load) |=> $stable(st_q.cnt));
    // R2
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);
    // R12
    foreign_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && cmd_addr != SEL_ADDR) |=> $stable(st_q.sel));
endmodule

// File: rtl/dco_accum.sv
module dco_accum
    import dco_pkg::*;
#(
    parameter int SMP_W_P = SMP_W,
    parameter int LOG_N_P = LOG_N,
    localparam int ACC_W  = SMP_W_P + LOG_N_P
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               last,
    input  logic [SMP_W_P-1:0] smp,
    output logic [SMP_W_P-1:0] avg
);
    typedef struct packed {
        logic [ACC_W-1:0]   acc;
        logic [SMP_W_P-1:0] avg;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum  = st_q.acc + {{LOG_N_P{smp[SMP_W_P-1]}}, smp};
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (en) begin
            if (last) begin
                st_d.avg = sum[ACC_W-1:LOG_N_P];
                st_d.acc = '0;
            end else begin
                st_d.acc = sum;
            end
        end
        avg = st_q.avg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && last && !clr) |=> $stable(st_q.avg));
    // R6
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.acc == '0));
endmodule

// File: rtl/dco_trim.sv
module dco_trim
    import dco_pkg::*;
#(
    parameter int SMP_W_P = SMP_W
) (
    input  logic [SMP_W_P-1:0] smp,
    input  logic [SMP_W_P-1:0] ofs,
    input  logic               sub_en,
    input  logic               floor_zero,
    output logic [SMP_W_P-1:0] res
);
    localparam logic [SMP_W_P-1:0] POS_MAX = {1'b0, {(SMP_W_P-1){1'b1}}};
    localparam logic [SMP_W_P-1:0] NEG_MAX = {1'b1, {(SMP_W_P-1){1'b0}}};

    logic [SMP_W_P:0] diff;

    always_comb begin
        diff = {smp[SMP_W_P-1], smp} - {ofs[SMP_W_P-1], ofs};
        if (!sub_en) begin
            res = smp;
        end else if (floor_zero && diff[SMP_W_P]) begin
            res = '0;
        end else if (diff[SMP_W_P] != diff[SMP_W_P-1]) begin
            res = diff[SMP_W_P] ? NEG_MAX : POS_MAX;
        end else begin
            res = diff[SMP_W_P-1:0];
        end
    end
endmodule

// File: rtl/dc_offset_trim.sv
module dc_offset_trim
    import dco_pkg::*;
#(
    parameter int SMP_W_P  = SMP_W,
    parameter int LOG_N_P  = LOG_N,
    parameter int ADDR_W_P = ADDR_W,
    parameter int DATA_W_P = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_load,
    input  logic [ADDR_W_P-1:0] cmd_addr,
    input  logic [DATA_W_P-1:0] cmd_data,
    input  logic                smp_stb,
    input  logic [SMP_W_P-1:0]  vc_in,
    input  logic [SMP_W_P-1:0]  fe_in,
    input  logic [SMP_W_P-1:0]  rf_in,
    input  logic [SMP_W_P-1:0]  te_in,
    output logic [SMP_W_P-1:0]  fcs_out,
    output logic [SMP_W_P-1:0]  trk_out,
    output logic [SMP_W_P-1:0]  rf_out,
    output logic [SMP_W_P-1:0]  fzc_out,
    output logic                status_out
);
    logic             restart, take, last;
    logic [NCH-1:0]   mask;
    trim_sel_t        sel;
    logic [SMP_W_P-1:0] ch_smp [NCH];
    logic [SMP_W_P-1:0] ch_avg [NCH];
    logic [SMP_W_P-1:0] fe_ofs, te_ofs;

    dco_ctrl #(
        .ADDR_W_P(ADDR_W_P), .DATA_W_P(DATA_W_P), .LOG_N_P(LOG_N_P),
        .NCH_P(NCH), .SEL_ADDR(ADDR_W_P'(TRIM_ADDR))
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .smp_stb(smp_stb), .restart(restart), .take(take),
        .last(last), .mask(mask), .sel(sel), .status(status_out)
    );

    always_comb begin
        ch_smp[CH_VC] = vc_in;
        ch_smp[CH_FE] = fe_in;
        ch_smp[CH_RF] = rf_in;
        ch_smp[CH_TE] = te_in;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_acc
        dco_accum #(.SMP_W_P(SMP_W_P), .LOG_N_P(LOG_N_P)) u_acc (
            .clk(clk), .rst_n(rst_n), .clr(restart),
            .en(take && mask[i]), .last(last && mask[i]),
            .smp(ch_smp[i]), .avg(ch_avg[i])
        );
    end

    // own offset has priority over centre offset on both paths
    always_comb begin
        fe_ofs = sel.fe_own ? ch_avg[CH_FE] : ch_avg[CH_VC];
        te_ofs = sel.te_own ? ch_avg[CH_TE] : ch_avg[CH_VC];
    end

    dco_trim #(.SMP_W_P(SMP_W_P)) u_fcs (
        .smp(fe_in), .ofs(fe_ofs), .sub_en(sel.fe_own || sel.fe_vc),
        .floor_zero(1'b0), .res(fcs_out)
    );
    dco_trim #(.SMP_W_P(SMP_W_P)) u_trk (
        .smp(te_in), .ofs(te_ofs), .sub_en(sel.te_own || sel.te_vc),
        .floor_zero(1'b0), .res(trk_out)
    );
    dco_trim #(.SMP_W_P(SMP_W_P)) u_rf (
        .smp(rf_in), .ofs(ch_avg[CH_RF]), .sub_en(sel.rf_floor),
        .floor_zero(1'b1), .res(rf_out)
    );
    dco_trim #(.SMP_W_P(SMP_W_P)) u_fzc (
        .smp(fe_in), .ofs(ch_avg[CH_FE]), .sub_en(1'b1),
        .floor_zero(1'b0), .res(fzc_out)
    );

    // R7
    rf_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel.rf_floor |-> !rf_out[SMP_W_P-1]);
    // R8
    fcs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel.fe_own && !sel.fe_vc) |-> (fcs_out == fe_in));
    // R9
    trk_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel.te_own && !sel.te_vc) |-> (trk_out == te_in));
    // R5
    status_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_out |-> (mask != '0));
endmodule

// File: tb/dc_offset_trim_tb.sv
module dc_offset_trim_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_load = 1'b0;
    logic [7:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic smp_stb = 1'b0;
    logic signed [7:0] vc_in = '0, fe_in = '0, rf_in = '0, te_in = '0;
    logic signed [7:0] fcs_out, trk_out, rf_out, fzc_out;
    logic status_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model
    int avg_m [4];
    int sum_m [4];
    int cnt_m = 0;
    bit [3:0] mask_m = '0;
    bit [7:0] addr_m = '0;
    bit rf_fl = 0, fe_own = 0, fe_vc = 0, te_own = 0, te_vc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_offset_trim u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .smp_stb(smp_stb), .vc_in(vc_in), .fe_in(fe_in),
        .rf_in(rf_in), .te_in(te_in), .fcs_out(fcs_out), .trk_out(trk_out),
        .rf_out(rf_out), .fzc_out(fzc_out), .status_out(status_out)
    );

    function automatic int sat8(int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int exp_fcs();
        if (fe_own) return sat8(int'(fe_in) - avg_m[1]);
        if (fe_vc) return sat8(int'(fe_in) - avg_m[0]);
        return int'(fe_in);
    endfunction

    function automatic int exp_trk();
        if (te_own) return sat8(int'(te_in) - avg_m[3]);
        if (te_vc) return sat8(int'(te_in) - avg_m[0]);
        return int'(te_in);
    endfunction

    function automatic int exp_rf();
        int d;
        if (!rf_fl) return int'(rf_in);
        d = int'(rf_in) - avg_m[2];
        if (d < 0) return 0;
        return sat8(d);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rand_inputs();
        vc_in = 8'($urandom);
        fe_in = 8'($urandom);
        rf_in = 8'($urandom);
        te_in = 8'($urandom);
    endtask

    task automatic check_outputs(string req);
        #1;
        check({req, " R8 fcs"}, int'(fcs_out), exp_fcs());
        check({req, " R9 trk"}, int'(trk_out), exp_trk());
        check({req, " R7 rf"}, int'(rf_out), exp_rf());
        check({req, " R10 fzc"}, int'(fzc_out), sat8(int'(fe_in) - avg_m[1]));
    endtask

    task automatic check_status(string req);
        #1;
        check({req, " status"}, int'(status_out),
              int'(mask_m != 0 && addr_m == 8'h38));
    endtask

    // latch a command; with_stb raises a strobe in the same cycle (R4: not counted)
    task automatic latch(bit [7:0] a, bit [15:0] d, bit with_stb);
        @(negedge clk);
        cmd_load = 1'b1;
        cmd_addr = a;
        cmd_data = d;
        smp_stb  = with_stb;
        addr_m   = a;
        if (a == 8'h38) begin
            mask_m = {d[4], d[11], d[13], d[15]};
            for (int i = 0; i < 4; i++) sum_m[i] = 0;
            cnt_m  = 0;
            rf_fl  = d[12];
            fe_own = d[10];
            fe_vc  = d[3];
            te_own = d[1];
            te_vc  = d[2];
        end
        @(negedge clk);
        cmd_load = 1'b0;
        smp_stb  = 1'b0;
    endtask

    // mode 0 random, 1 all -128, 2 all 127
    task automatic strobes(int n, int mode, string req);
        for (int k = 0; k < n; k++) begin
            int gap;
            gap = int'($urandom % 3);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                rand_inputs();
            end
            @(negedge clk);
            if (mode == 1) begin
                vc_in = -8'sd128; fe_in = -8'sd128; rf_in = -8'sd128; te_in = -8'sd128;
            end else if (mode == 2) begin
                vc_in = 8'sd127; fe_in = 8'sd127; rf_in = 8'sd127; te_in = 8'sd127;
            end else begin
                rand_inputs();
            end
            smp_stb = 1'b1;
            if (mask_m != 0) begin
                sum_m[0] += int'(vc_in);
                sum_m[1] += int'(fe_in);
                sum_m[2] += int'(rf_in);
                sum_m[3] += int'(te_in);
                cnt_m++;
                if (cnt_m == 256) begin
                    for (int i = 0; i < 4; i++)
                        if (mask_m[i]) avg_m[i] = sum_m[i] >>> 8;
                    mask_m = '0;
                end
            end
            @(negedge clk);
            smp_stb = 1'b0;
            check_status(req);
        end
    endtask

    task automatic random_trims(int n, string req);
        for (int k = 0; k < n; k++) begin
            bit [15:0] w;
            w = 16'($urandom) & 16'h140E;
            latch(8'h38, w, 1'b0);
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                rand_inputs();
                check_outputs(req);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 4; i++) begin
            avg_m[i] = 0;
            sum_m[i] = 0;
        end
        rand_inputs();
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_status("R1");
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            rand_inputs();
            check_outputs("R1");
        end

        // R4: strobes while idle are ignored
        strobes(20, 0, "R4 idle");
        check_outputs("R4 idle");

        // R2: centre and focus measured with random samples
        latch(8'h38, 16'hA000, 1'b0);
        check_status("R2 start");
        strobes(256, 0, "R2");
        random_trims(10, "R2");

        // R3: RF at -128 only, others keep theirs
        latch(8'h38, 16'h0800, 1'b1);
        strobes(256, 1, "R3");
        random_trims(10, "R3");

        // R5: tracking measured at 127, foreign address hides busy mid-run
        latch(8'h38, 16'h0010, 1'b0);
        strobes(100, 2, "R5");
        latch(8'h20, 16'hFFFF, 1'b0);
        check_status("R5 hidden");
        check_outputs("R12 foreign");
        strobes(156, 2, "R5");
        latch(8'h38, 16'h0002, 1'b0);
        @(negedge clk);
        te_in = -8'sd128;
        check_outputs("R11 low sat");
        check("R5 te offset", int'(trk_out), -128 - 127 < -128 ? -128 : 0);

        // R11: RF clamp with -128 offset, rf=127 saturates high
        latch(8'h38, 16'h1000, 1'b0);
        @(negedge clk);
        rf_in = 8'sd127;
        #1;
        check("R11 rf high sat", int'(rf_out), 127);

        // R6: restart keeps only last 256 samples
        latch(8'h38, 16'h0800, 1'b0);
        strobes(100, 2, "R6");
        latch(8'h38, 16'h0800, 1'b0);
        strobes(256, 0, "R6");
        random_trims(8, "R6");

        // R6: abort leaves offsets unchanged
        latch(8'h38, 16'h8000, 1'b0);
        strobes(50, 2, "R6 abort");
        latch(8'h38, 16'h0000, 1'b0);
        check_status("R6 abort");
        strobes(10, 0, "R6 abort");
        latch(8'h38, 16'h0008, 1'b0);
        @(negedge clk);
        rand_inputs();
        check_outputs("R6 abort");

        // focus at 127 and random mix of selections
        latch(8'h38, 16'h2000, 1'b0);
        strobes(256, 2, "R2 max");
        latch(8'h38, 16'h0400, 1'b0);
        @(negedge clk);
        fe_in = -8'sd128;
        #1;
        check("R11 fcs low sat", int'(fcs_out), -128);
        random_trims(30, "R8 R9 R10 R11");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule